// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending Queue

This block holds the logging state for uncorrectable errors of one PCIe function in an advanced error reporting capability. When an error is recorded, it captures the position of the error's status bit as a first-error pointer. It also captures the header of the offending TLP as four dwords and, when enabled, the TLP prefix as four dwords. It keeps a 32-bit uncorrectable status register whose bits are cleared by writing ones.

While software has not yet cleared the status bit of the first error, further errors are held in a small queue, provided multiple-header recording is enabled. Software acknowledges an error by writing a one to its status bit. The block then promotes the oldest queued error into the log. It also sets again the status bits of every error still waiting, so none of them is lost to the write-one-to-clear operation. If the queue is full, the block drops the new error and raises a one-cycle overflow pulse. Severity decoding and message routing happen elsewhere.

Top module: `aer_hdr_log`

## Requirements
- R1: After reset the status register, the first-error pointer, both logs, the prefix flag, the enable bit, the overflow pulse and the queue count are all zero. The capable bit reads 1 when `Q_DEPTH` > 0.
- R2: A record request carries a status with exactly one bit set. If it is logged, the pointer becomes that bit's index one cycle later. In every case the status bit is set one cycle later.
- R3: When the header-valid flag is set, each header dword i (`rec_hdr[32i+31:32i]`) is stored with its four bytes in reverse order: input byte 0 (bits 7:0) lands in bits 31:24. When the flag is clear, all four header dwords read zero.
- R4: The prefix log is stored with the same byte reversal, and `pfx_logged` set, only when the record has its prefix flag set and `e2e_pfx_en` is 1. Otherwise the prefix log is zero and `pfx_logged` is clear.
- R5: When multiple-header recording is enabled and the status bit at the current pointer is set, a new record goes to the queue tail. The log is left unchanged and the queue count rises by one.
- R6: In that same situation with the queue holding `Q_DEPTH` entries, the record is dropped and the count stays the same. `log_overflow` is high in the next cycle only.
- R7: A config write that leaves the pointer's status bit clear, with the enable bit on and a non-empty queue, sets the status bits of all queued entries again. It then moves the oldest entry into the log (pointer, header and prefix) and lowers the count by one.
- R8: A config write that leaves the pointer's status bit clear, with an empty queue or the enable bit off, zeroes the pointer, both logs and the prefix flag.
- R9: A config write that leaves the pointer's status bit set, with the enable bit on, sets the status bits of all queued entries again.
- R10: A config write that leaves the pointer's status bit set, with the enable bit off, empties the queue.
- R11: The enable bit can be written only when `Q_DEPTH` > 0. A write to it takes effect in the same evaluation as a status write.
- R12: With the enable bit off, each record overwrites the log, even while the first error's status bit is still set.
- R13: A status write clears exactly the bits written as one, apart from the bits restored by R7 or R9. A record sets its status bit even when R6 drops the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record request strobe, never in the same cycle as a config write |
| rec_status | input | 32 | One-hot uncorrectable status of the error |
| rec_hdr_valid | input | 1 | Header words are meaningful |
| rec_pfx_present | input | 1 | Prefix words are meaningful |
| rec_hdr | input | 128 | Four header dwords, dword i at bits 32i+31:32i |
| rec_pfx | input | 128 | Four prefix dwords, same layout |
| e2e_pfx_en | input | 1 | End-to-end prefix logging is supported and enabled |
| ustat_we | input | 1 | Write strobe for the status register |
| ustat_w1c | input | 32 | Ones clear the matching status bits |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_mhr_en | input | 1 | New value of the multiple-header enable bit |
| ustat | output | 32 | Uncorrectable status register |
| first_err_ptr | output | 5 | First-error pointer |
| mhr_capable | output | 1 | Multiple-header recording is available |
| mhr_enable | output | 1 | Multiple-header recording is enabled |
| pfx_logged | output | 1 | Prefix log holds a valid prefix |
| hdr_log | output | 128 | Header log |
| pfx_log | output | 128 | Prefix log |
| log_overflow | output | 1 | One-cycle pulse when a record was dropped |
| q_count | output | 3 | Number of queued records |

## Verification
Every result is registered once. A record or config write presented before a rising edge shows up at the outputs right after that edge, and that includes the overflow pulse. The bench applies each stimulus at the falling edge and predicts the whole register image for the edge that follows. The scoreboard samples a quarter period after that rising edge, so each prediction is compared in exactly the cycle its effect is due. Idle cycles also push a prediction, which shows that the overflow pulse falls after one cycle and that nothing drifts between operations.

// File: rtl/aerlog_pkg.sv
package aerlog_pkg;
  localparam int STAT_W    = 32;
  localparam int FEP_W     = $clog2(STAT_W);
  localparam int LOG_WORDS = 4;
  localparam int LOG_W     = 32 * LOG_WORDS;

  typedef struct packed {
    logic [STAT_W-1:0] status;
    logic              hdr_ok;
    logic              pfx_ok;
    logic [LOG_W-1:0]  hdr;
    logic [LOG_W-1:0]  pfx;
  } err_rec_t;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [LOG_W-1:0] swap_log(input logic [LOG_W-1:0] d);
    logic [LOG_W-1:0] r;
    for (int i = 0; i < LOG_WORDS; i++) r[32*i +: 32] = swap32(d[32*i +: 32]);
    return r;
  endfunction

  function automatic logic [FEP_W-1:0] bit_index(input logic [STAT_W-1:0] v);
    logic [FEP_W-1:0] r;
    r = '0;
    for (int i = 0; i < STAT_W; i++) if (v[i]) r = FEP_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/aerlog_hdr_regs.sv
module aerlog_hdr_regs
  import aerlog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  err_rec_t          rec,
  input  logic              e2e_en,
  output logic [FEP_W-1:0]  fep,
  output logic [LOG_W-1:0]  hdr_log,
  output logic [LOG_W-1:0]  pfx_log,
  output logic              pfx_flag
);
  logic pfx_take;
  assign pfx_take = rec.pfx_ok & e2e_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fep      <= '0;
      hdr_log  <= '0;
      pfx_log  <= '0;
      pfx_flag <= 1'b0;
    end else if (clear) begin
      fep      <= '0;
      hdr_log  <= '0;
      pfx_log  <= '0;
      pfx_flag <= 1'b0;
    end else if (load) begin
      fep      <= bit_index(rec.status);
      hdr_log  <= rec.hdr_ok ? swap_log(rec.hdr) : '0;
      pfx_log  <= pfx_take ? swap_log(rec.pfx) : '0;
      pfx_flag <= pfx_take;
    end
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fep == '0 && hdr_log == '0 && pfx_log == '0 && !pfx_flag));
  // R3
  no_hdr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && !rec.hdr_ok) |=> hdr_log == '0);
  // R4
  pfx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear && !(rec.pfx_ok && e2e_en)) |=> (!pfx_flag && pfx_log == '0));
  // R8
  load_clear_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && clear));
endmodule

// File: rtl/aerlog_pend_q.sv
module aerlog_pend_q
  import aerlog_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = (DEPTH < 1) ? 1 : $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  err_rec_t          push_rec,
  output err_rec_t          head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic [STAT_W-1:0] status_or
);
  err_rec_t slots [DEPTH];

  assign head = slots[0];
  assign full = (count == CW'(DEPTH));

  always_comb begin
    status_or = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < count) status_or = status_or | slots[i].status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (flush) begin
      count <= '0;
    end else if (pop && count != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) slots[i] <= slots[i+1];
      count <= count - 1'b1;
    end else if (push && !full) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == count) slots[i] <= push_rec;
      count <= count + 1'b1;
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !flush) |=> count == $past(count) + 1'b1);
  // R7
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush && count != '0) |=> count == $past(count) - 1'b1);
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
endmodule

// File: rtl/aer_hdr_log.sv
module aer_hdr_log
  import aerlog_pkg::*;
#(
  parameter  int Q_DEPTH = 4,
  localparam int QCW     = (Q_DEPTH < 1) ? 1 : $clog2(Q_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [31:0]       rec_status,
  input  logic              rec_hdr_valid,
  input  logic              rec_pfx_present,
  input  logic [127:0]      rec_hdr,
  input  logic [127:0]      rec_pfx,
  input  logic              e2e_pfx_en,
  input  logic              ustat_we,
  input  logic [31:0]       ustat_w1c,
  input  logic              ctl_we,
  input  logic              ctl_mhr_en,
  output logic [31:0]       ustat,
  output logic [4:0]        first_err_ptr,
  output logic              mhr_capable,
  output logic              mhr_enable,
  output logic              pfx_logged,
  output logic [127:0]      hdr_log,
  output logic [127:0]      pfx_log,
  output logic              log_overflow,
  output logic [QCW-1:0]    q_count
);
  localparam bit MHR_CAP = (Q_DEPTH > 0);

  err_rec_t          in_rec, q_head, log_src;
  logic              q_push, q_pop, q_flush, q_full;
  logic [STAT_W-1:0] q_or;
  logic              log_load, log_clear;
  logic              cfg_any, mhr_en_n, fe_set, take_q, ovf_n;
  logic [STAT_W-1:0] ust_w, ust_n;

  assign in_rec = '{status: rec_status, hdr_ok: rec_hdr_valid, pfx_ok: rec_pfx_present,
                    hdr: rec_hdr, pfx: rec_pfx};
  assign mhr_capable = MHR_CAP;

  generate
    if (Q_DEPTH > 0) begin : g_queue
      aerlog_pend_q #(.DEPTH(Q_DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(q_push), .pop(q_pop), .flush(q_flush),
        .push_rec(in_rec), .head(q_head), .count(q_count), .full(q_full),
        .status_or(q_or));
    end else begin : g_noqueue
      assign q_head  = '0;
      assign q_count = '0;
      assign q_full  = 1'b1;
      assign q_or    = '0;
    end
  endgenerate

  // post-write view of the registers
  assign cfg_any  = ustat_we | ctl_we;
  assign mhr_en_n = ctl_we ? (ctl_mhr_en & MHR_CAP) : mhr_enable;
  assign ust_w    = ustat_we ? (ustat & ~ustat_w1c) : ustat;
  assign fe_set   = ust_w[first_err_ptr];
  assign take_q   = rec_valid & mhr_enable & ustat[first_err_ptr];
  assign log_src  = cfg_any ? q_head : in_rec;

  always_comb begin
    ust_n     = ustat;
    q_push    = 1'b0;
    q_pop     = 1'b0;
    q_flush   = 1'b0;
    log_load  = 1'b0;
    log_clear = 1'b0;
    ovf_n     = 1'b0;
    if (cfg_any) begin
      ust_n = ust_w;
      if (!fe_set) begin
        if (mhr_en_n && q_count != '0) begin
          ust_n    = ust_w | q_or;
          q_pop    = 1'b1;
          log_load = 1'b1;
        end else begin
          log_clear = 1'b1;
        end
      end else if (mhr_en_n) begin
        ust_n = ust_w | q_or;
      end else begin
        q_flush = 1'b1;
      end
    end else if (rec_valid) begin
      ust_n = ustat | rec_status;
      if (take_q) begin
        q_push = ~q_full;
        ovf_n  = q_full;
      end else begin
        log_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ustat        <= '0;
      mhr_enable   <= 1'b0;
      log_overflow <= 1'b0;
    end else begin
      ustat        <= ust_n;
      mhr_enable   <= mhr_en_n;
      log_overflow <= ovf_n;
    end
  end

  aerlog_hdr_regs u_log (
    .clk(clk), .rst_n(rst_n), .load(log_load), .clear(log_clear), .rec(log_src),
    .e2e_en(e2e_pfx_en), .fep(first_err_ptr), .hdr_log(hdr_log), .pfx_log(pfx_log),
    .pfx_flag(pfx_logged));

  // R2
  rec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $onehot(rec_status));
  // R2
  rec_cfg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid && cfg_any));
  // R13
  rec_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> (ustat & $past(rec_status)) == $past(rec_status));
  // R6
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_overflow |-> ($past(rec_valid) && $past(mhr_enable) && $past(q_full)));
  // R9
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_any && fe_set && mhr_en_n) |=> (ustat & $past(q_or)) == $past(q_or));
  // R7
  reload_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> first_err_ptr == $past(bit_index(q_head.status)));
  // R11
  enable_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mhr_enable |-> mhr_capable);
endmodule

// File: tb/sim_aer_hdr_log.sv
module sim_aer_hdr_log;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         rec_valid = 0, rec_hdr_valid = 0, rec_pfx_present = 0, e2e_pfx_en = 0;
  logic [31:0]  rec_status = '0, ustat_w1c = '0;
  logic [127:0] rec_hdr = '0, rec_pfx = '0;
  logic         ustat_we = 0, ctl_we = 0, ctl_mhr_en = 0;
  logic [31:0]  ustat;
  logic [4:0]   first_err_ptr;
  logic         mhr_capable, mhr_enable, pfx_logged, log_overflow;
  logic [127:0] hdr_log, pfx_log;
  logic [2:0]   q_count;

  aer_hdr_log #(.Q_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
    .rec_hdr_valid(rec_hdr_valid), .rec_pfx_present(rec_pfx_present), .rec_hdr(rec_hdr),
    .rec_pfx(rec_pfx), .e2e_pfx_en(e2e_pfx_en), .ustat_we(ustat_we), .ustat_w1c(ustat_w1c),
    .ctl_we(ctl_we), .ctl_mhr_en(ctl_mhr_en), .ustat(ustat), .first_err_ptr(first_err_ptr),
    .mhr_capable(mhr_capable), .mhr_enable(mhr_enable), .pfx_logged(pfx_logged),
    .hdr_log(hdr_log), .pfx_log(pfx_log), .log_overflow(log_overflow), .q_count(q_count));

  typedef struct { logic [31:0] st; bit hv; bit pp; logic [127:0] h; logic [127:0] p; } mrec_t;
  typedef struct { string tag; logic [31:0] us; logic [4:0] fp; logic [127:0] h; logic [127:0] p;
                   bit fl; bit mh; bit ov; int cn; } exp_t;

  exp_t  expq[$];
  mrec_t mq[$];
  logic [31:0]  m_us = '0;
  logic [4:0]   m_fp = '0;
  logic [127:0] m_h = '0, m_p = '0;
  bit m_fl = 0, m_mh = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [127:0] rev_bytes(input logic [127:0] d);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = d[32*i +: 32];
      r[32*i +: 32] = {<<8{w}};
    end
    return r;
  endfunction

  function automatic logic [4:0] pos_of(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [127:0] pattern(input logic [7:0] s);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[8*i +: 8] = s + 8'(i * 17);
    return r;
  endfunction

  function void m_load(mrec_t r, bit e2e);
    m_fp = pos_of(r.st);
    m_h  = r.hv ? rev_bytes(r.h) : '0;
    m_fl = r.pp && e2e;
    m_p  = m_fl ? rev_bytes(r.p) : '0;
  endfunction

  function void push_exp(string tag, bit ov);
    exp_t e;
    e.tag = tag; e.us = m_us; e.fp = m_fp; e.h = m_h; e.p = m_p;
    e.fl = m_fl; e.mh = m_mh; e.ov = ov; e.cn = mq.size();
    expq.push_back(e);
  endfunction

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_rec(string tag, logic [31:0] st, bit hv, bit pp, logic [7:0] seed, bit e2e);
    mrec_t r;
    bit ov;
    @(negedge clk);
    r.st = st; r.hv = hv; r.pp = pp; r.h = pattern(seed); r.p = pattern(seed ^ 8'hA5);
    rec_valid = 1; rec_status = st; rec_hdr_valid = hv; rec_pfx_present = pp;
    rec_hdr = r.h; rec_pfx = r.p; e2e_pfx_en = e2e;
    ov = 0;
    if (m_mh && m_us[m_fp]) begin
      if (mq.size() == DEPTH) ov = 1;
      else mq.push_back(r);
    end else m_load(r, e2e);
    m_us = m_us | st;
    push_exp(tag, ov);
    @(posedge clk); #1;
    rec_valid = 0;
  endtask

  task automatic do_wr(string tag, bit uwe, logic [31:0] w1c, bit cwe, bit cval);
    logic [31:0] orq;
    @(negedge clk);
    ustat_we = uwe; ustat_w1c = w1c; ctl_we = cwe; ctl_mhr_en = cval;
    if (cwe) m_mh = cval;
    if (uwe) m_us = m_us & ~w1c;
    orq = '0;
    foreach (mq[i]) orq = orq | mq[i].st;
    if (!m_us[m_fp]) begin
      if (m_mh && mq.size() > 0) begin
        m_us = m_us | orq;
        m_load(mq.pop_front(), e2e_pfx_en);
      end else begin
        m_fp = '0; m_h = '0; m_p = '0; m_fl = 0;
      end
    end else if (m_mh) m_us = m_us | orq;
    else mq.delete();
    push_exp(tag, 0);
    @(posedge clk); #1;
    ustat_we = 0; ctl_we = 0;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    push_exp(tag, 0);
  endtask

  // scoreboard monitor: compares a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk); #5;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        chk(e.tag, "ustat", 128'(ustat), 128'(e.us));
        chk(e.tag, "first_err_ptr", 128'(first_err_ptr), 128'(e.fp));
        chk(e.tag, "hdr_log", hdr_log, e.h);
        chk(e.tag, "pfx_log", pfx_log, e.p);
        chk(e.tag, "pfx_logged", 128'(pfx_logged), 128'(e.fl));
        chk(e.tag, "mhr_enable", 128'(mhr_enable), 128'(e.mh));
        chk(e.tag, "log_overflow", 128'(log_overflow), 128'(e.ov));
        chk(e.tag, "q_count", 128'(q_count), 128'(e.cn));
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 reset state");
    @(negedge clk);
    chk("R1/R11", "mhr_capable", 128'(mhr_capable), 128'(1));
    // R2 R3 R4: first error, header and prefix logged
    do_rec("R2 R3 R4 first record", 32'h0000_0010, 1, 1, 8'h10, 1);
    // R12 R3 R4: overwrite with recording off, no header, prefix gated
    do_rec("R12 R3 R4 overwrite", 32'h0000_0080, 0, 1, 8'h20, 0);
    // R8 R13: clear everything with empty queue
    do_wr("R8 R13 clear all", 1, 32'hFFFF_FFFF, 0, 0);
    // R11: enable multiple-header recording
    do_wr("R11 enable write", 0, '0, 1, 1);
    do_rec("R2 log with enable", 32'h0000_0004, 1, 0, 8'h30, 1);
    // R5: queue four
    do_rec("R5 queue 1", 32'h0000_0200, 1, 1, 8'h40, 1);
    do_rec("R5 queue 2", 32'h0000_0800, 0, 1, 8'h50, 1);
    do_rec("R5 queue 3", 32'h0000_2000, 1, 0, 8'h60, 1);
    do_rec("R5 queue 4", 32'h0000_8000, 1, 1, 8'h70, 1);
    // R6: overflow, pulse one cycle, status bit still set (R13)
    do_rec("R6 R13 overflow", 32'h0010_0000, 1, 1, 8'h80, 1);
    idle("R6 pulse ends");
    // R9 R13: partial clear, queued bit restored, other bit cleared
    do_wr("R9 R13 partial clear", 1, 32'h0010_0200, 0, 0);
    // R7: clear first error, head promoted
    do_wr("R7 reload 1", 1, 32'h0000_0004, 0, 0);
    // R7: again, entry without header
    do_wr("R7 reload 2", 1, 32'h0000_0200, 0, 0);
    // R10: disable while first bit set flushes queue
    do_wr("R10 flush", 0, '0, 1, 0);
    // R8: clear with recording off
    do_wr("R8 clear after flush", 1, 32'hFFFF_FFFF, 0, 0);
    // R7 R13 same-cycle enable write and first-bit clear
    do_wr("R11 re-enable", 0, '0, 1, 1);
    do_rec("R2 new first", 32'h0000_0001, 1, 1, 8'h90, 1);
    do_rec("R5 queue again", 32'h4000_0000, 1, 1, 8'hA0, 1);
    do_wr("R7 R11 combined write", 1, 32'h0000_0001, 1, 1);
    idle("R7 settle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule